// File: doc/BRIEF.md
# Layered Debug Access Gate

This block decides whether the two debug scan chains of a chip may be used. One chain reaches the processor's debug access port. The other reaches the programmable-logic side. The block also drives the four processor debug-mode enables and a permit for reads of the internal boot ROM.

Three independent blockers stand in front of every enable:
- **Fuse bit.** A one-time fuse bit that is a plain level input and cannot be undone.
- **Control register.** A software-writable control register.
- **Lock flag.** A sticky lock flag that only a power-on reset clears.

A secure-boot status input shuts everything off while secure boot runs. That includes the ROM read permit. The three soft-reset sources are watchdog, software and debug-port. Each of them drops the processor debug enables, but leaves chain routing and the lock alone.

Software uses a small synchronous register port. A one-cycle write strobe carries a one-bit address. Address 0 is the control register and address 1 is the lock. Read data is combinational from the address. There is no back-pressure: every write strobe is taken in the cycle it is presented. Outputs follow the register state with no added latency, so a write becomes visible right after the clock edge that captures it.

Top module: `dbg_access_gate`

## Requirements
- R1: While `fuse_dbg_off` is 1, `dap_chain_en`, `logic_chain_en` and all four `dbg_mode_en` bits are 0, whatever the register contents.
- R2: After power-on reset the control register holds 0x02, which disables both chains and all debug modes. `rom_read_ok` is 1 and the lock is clear.
- R3: The control register fields are:
  - bit 0: chain concatenation select.
  - bit 1: logic-chain disable.
  - bit 2: processor DAP enable.
  - bits 6:3: debug-mode enables, in the order invasive, non-invasive, secure non-invasive, secure invasive.
  In separate-chain mode (bit 0 = 0), `dap_chain_en` follows bit 2 and `logic_chain_en` follows the inverse of bit 1.
- R4: In concatenated mode (bit 0 = 1), `dap_chain_en` and `logic_chain_en` are equal. Both are 1 only when bit 2 is 1 and bit 1 is 0. `chain_concat` mirrors bit 0.
- R5: `dbg_mode_en[i]` is 1 only when control bit 3+i is 1 and `dap_chain_en` is 1.
- R6: Writing address 1 with data bit 0 set raises the lock, which forces all chain and mode enables to 0. Writing 0 there does not clear it, and neither does any soft reset. Only `por_n` low clears it.
- R7: While the lock is set, writes to address 0 are ignored. This is visible on `chain_concat` and on the read-back of bit 0.
- R8: A pulse on `rst_wdt`, `rst_sw` or `rst_jtag` clears control bits 6:2. Bits 1:0 are kept, and a soft reset wins over a write in the same cycle.
- R9: While `secure_boot_busy` is 1, `rom_read_ok` and every chain and mode enable are 0. They return once the input falls.
- R10: Reading address 0 returns the effective values:
  - bit 0: concatenation select.
  - bit 1: logic chain off, the inverse of `logic_chain_en`.
  - bit 2: `dap_chain_en`.
  - bits 6:3: `dbg_mode_en`.
  - bit 7: 0.

  Reading address 1 returns the lock in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_wdt | input | 1 | Watchdog soft reset, synchronous, active high |
| rst_sw | input | 1 | Software soft reset, synchronous, active high |
| rst_jtag | input | 1 | Debug-port soft reset, synchronous, active high |
| fuse_dbg_off | input | 1 | Debug-disable fuse state |
| secure_boot_busy | input | 1 | Secure boot in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 lock |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| dap_chain_en | output | 1 | Processor debug chain enable |
| logic_chain_en | output | 1 | Logic-side chain enable |
| chain_concat | output | 1 | Chains joined into one |
| dbg_mode_en | output | 4 | Debug-mode enables, bit 0 invasive to bit 3 secure invasive |
| rom_read_ok | output | 1 | Internal ROM reads permitted |

## Verification
The bench drives the fuse and secure-boot inputs with register values under which the chains would otherwise be open. A gate that honoured the register over either blocker would show a live enable there.

The lock is hit with a zero write, with each soft-reset source, and with a control write that would flip the concatenation bit. A lock that a soft reset cleared, or one that left writes through, would change `reg_rdata` or `chain_concat`.

Concatenated mode is run with exactly one of the two chain bits open. A design that kept per-chain enables in that mode would open one chain alone.

Soft resets are checked to keep the routing bits. A reset that wiped the whole register would turn off the logic chain.

// File: rtl/dbg_access_pkg.sv
package dbg_access_pkg;
  parameter int unsigned NUM_MODES = 4;

  typedef struct packed {
    logic [NUM_MODES-1:0] mode;   // bit 3+i in the register word
    logic                 dap_on;
    logic                 pl_off;
    logic                 concat;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  localparam ctrl_t CTRL_RST = '{mode: '0, dap_on: 1'b0, pl_off: 1'b1, concat: 1'b0};
endpackage

// File: rtl/dbg_access_regs.sv
module dbg_access_regs
  import dbg_access_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl_q,
  output logic              lock_q
);
  localparam int unsigned LOCK_BIT = 0;

  logic ctrl_wr;
  logic lock_set;

  assign ctrl_wr  = wr_en && !wr_addr && !lock_q;
  assign lock_set = wr_en && wr_addr && wr_data[LOCK_BIT];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctrl_q <= CTRL_RST;
    end else if (soft_rst) begin
      ctrl_q.dap_on <= 1'b0;
      ctrl_q.mode   <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) lock_q <= 1'b0;
    else if (lock_set) lock_q <= 1'b1;
  end

  // R6: once raised, the lock survives everything except power-on reset
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |=> lock_q);

  // R7: a locked register does not move except through a soft reset
  a_r7_ctrl_frozen: assert property (@(posedge clk) disable iff (!por_n)
    (lock_q && !soft_rst) |=> $stable(ctrl_q));

  // R8: soft reset drops DAP and mode bits, keeps routing bits
  a_r8_soft_clears: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> (!ctrl_q.dap_on && (ctrl_q.mode == '0) &&
                  (ctrl_q.concat == $past(ctrl_q.concat)) &&
                  (ctrl_q.pl_off == $past(ctrl_q.pl_off))));
endmodule

// File: rtl/dbg_access_combine.sv
module dbg_access_combine
  import dbg_access_pkg::*;
(
  input  ctrl_t                ctrl,
  input  logic                 fuse_off,
  input  logic                 locked,
  input  logic                 sboot,
  output logic                 dap_en,
  output logic                 pl_en,
  output logic [NUM_MODES-1:0] mode_en,
  output logic                 rom_ok
);
  logic blocked;
  logic dap_req;
  logic pl_req;

  assign blocked = fuse_off | locked | sboot;
  assign dap_req = ctrl.dap_on;
  assign pl_req  = !ctrl.pl_off;

  always_comb begin
    if (ctrl.concat) begin
      dap_en = !blocked && dap_req && pl_req;
      pl_en  = !blocked && dap_req && pl_req;
    end else begin
      dap_en = !blocked && dap_req;
      pl_en  = !blocked && pl_req;
    end
  end

  for (genvar i = 0; i < NUM_MODES; i++) begin : g_mode
    assign mode_en[i] = dap_en && ctrl.mode[i];
  end

  assign rom_ok = !sboot;

  always_comb begin
    if (fuse_off) begin
      a_r1_fuse_kills: assert (!dap_en && !pl_en && (mode_en == '0));
    end
    if (sboot) begin
      a_r9_secure_boot_off: assert (!rom_ok && !dap_en && !pl_en && (mode_en == '0));
    end
    if (ctrl.concat) begin
      a_r4_concat_same: assert (dap_en == pl_en);
    end
  end
endmodule

// File: rtl/dbg_access_gate.sv
module dbg_access_gate
  import dbg_access_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 rst_wdt,
  input  logic                 rst_sw,
  input  logic                 rst_jtag,
  input  logic                 fuse_dbg_off,
  input  logic                 secure_boot_busy,
  input  logic                 reg_wr,
  input  logic                 reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 dap_chain_en,
  output logic                 logic_chain_en,
  output logic                 chain_concat,
  output logic [NUM_MODES-1:0] dbg_mode_en,
  output logic                 rom_read_ok
);
  ctrl_t ctrl_q;
  logic  lock_q;
  logic  soft_rst;
  ctrl_t eff_view;

  assign soft_rst = rst_wdt | rst_sw | rst_jtag;

  dbg_access_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .por_n    (por_n),
    .soft_rst (soft_rst),
    .wr_en    (reg_wr),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata),
    .ctrl_q   (ctrl_q),
    .lock_q   (lock_q)
  );

  dbg_access_combine u_comb (
    .ctrl     (ctrl_q),
    .fuse_off (fuse_dbg_off),
    .locked   (lock_q),
    .sboot    (secure_boot_busy),
    .dap_en   (dap_chain_en),
    .pl_en    (logic_chain_en),
    .mode_en  (dbg_mode_en),
    .rom_ok   (rom_read_ok)
  );

  assign chain_concat = ctrl_q.concat;

  always_comb begin
    eff_view.mode   = dbg_mode_en;
    eff_view.dap_on = dap_chain_en;
    eff_view.pl_off = !logic_chain_en;
    eff_view.concat = ctrl_q.concat;
    reg_rdata = '0;
    if (reg_addr) reg_rdata[0] = lock_q;
    else          reg_rdata[CTRL_W-1:0] = eff_view;
  end

  // R6: a raised lock keeps every chain closed
  a_r6_locked_closed: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |-> (!dap_chain_en && !logic_chain_en && (dbg_mode_en == '0)));
endmodule

// File: tb/dbg_access_gate_tb.sv
`timescale 1ns/1ps
module dbg_access_gate_tb;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_wdt = 1'b0, rst_sw = 1'b0, rst_jtag = 1'b0;
  logic       fuse_dbg_off = 1'b0, secure_boot_busy = 1'b0;
  logic       reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       dap_chain_en, logic_chain_en, chain_concat, rom_read_ok;
  logic [3:0] dbg_mode_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbg_access_gate u_dut (
    .clk(clk), .por_n(por_n), .rst_wdt(rst_wdt), .rst_sw(rst_sw), .rst_jtag(rst_jtag),
    .fuse_dbg_off(fuse_dbg_off), .secure_boot_busy(secure_boot_busy),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dap_chain_en(dap_chain_en), .logic_chain_en(logic_chain_en),
    .chain_concat(chain_concat), .dbg_mode_en(dbg_mode_en), .rom_read_ok(rom_read_ok)
  );

  // {wdata, fuse, sboot, expected {rom, concat, logic_en, dap_en, modes[3:0]}}
  localparam logic [17:0] VEC [13] = '{
    {8'h04, 1'b0, 1'b0, 8'hB0},  // R3 dap only chain bits
    {8'h06, 1'b0, 1'b0, 8'h90},  // R3 logic chain disabled
    {8'h00, 1'b0, 1'b0, 8'hA0},  // R3 logic only
    {8'h7C, 1'b0, 1'b0, 8'hBF},  // R5 all modes
    {8'h78, 1'b0, 1'b0, 8'hA0},  // R5 modes without dap
    {8'h2C, 1'b0, 1'b0, 8'hB5},  // R5 partial modes
    {8'h05, 1'b0, 1'b0, 8'hF0},  // R4 joined, both open
    {8'h07, 1'b0, 1'b0, 8'hC0},  // R4 joined, logic bit off
    {8'h01, 1'b0, 1'b0, 8'hC0},  // R4 joined, dap bit off
    {8'h7C, 1'b1, 1'b0, 8'h80},  // R1 fuse
    {8'h7D, 1'b1, 1'b0, 8'hC0},  // R1 fuse joined
    {8'h7C, 1'b0, 1'b1, 8'h00},  // R9 secure boot
    {8'h7C, 1'b0, 1'b0, 8'hBF}   // R9 release
  };

  function automatic logic [7:0] obs();
    return {rom_read_ok, chain_concat, logic_chain_en, dap_chain_en, dbg_mode_en};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
    reg_addr = 1'b0;
  endtask

  task automatic por();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    chk("R2 outputs after por", obs(), 8'h80);
    rd(1'b0, r); chk("R2 ctrl readback", r, 8'h02);
    rd(1'b1, r); chk("R2 lock clear", r, 8'h00);

    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      fuse_dbg_off = VEC[i][9];
      secure_boot_busy = VEC[i][8];
      wr(1'b0, VEC[i][17:10]);
      chk($sformatf("R1/R3/R4/R5/R9 vector %0d", i), obs(), VEC[i][7:0]);
    end
    fuse_dbg_off = 1'b0; secure_boot_busy = 1'b0;

    // R10 readback of effective values
    wr(1'b0, 8'h2C);
    rd(1'b0, r); chk("R10 effective readback", r, 8'h2C);
    wr(1'b0, 8'h07);
    rd(1'b0, r); chk("R10 joined readback logic off", r, 8'h03);
    fuse_dbg_off = 1'b1;
    wr(1'b0, 8'h7C);
    rd(1'b0, r); chk("R10 R1 readback under fuse", r, 8'h02);
    fuse_dbg_off = 1'b0;

    // R8 soft resets keep routing, drop dap and modes
    wr(1'b0, 8'h7C);
    @(negedge clk); rst_wdt = 1'b1; @(negedge clk); rst_wdt = 1'b0;
    chk("R8 watchdog reset", obs(), 8'hA0);
    wr(1'b0, 8'h7D);
    @(negedge clk); rst_sw = 1'b1; @(negedge clk); rst_sw = 1'b0;
    chk("R8 software reset keeps concat", obs(), 8'hC0);
    rd(1'b0, r); chk("R8 readback after sw reset", r, 8'h03);
    wr(1'b0, 8'h7C);
    @(negedge clk); rst_jtag = 1'b1; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h7D;
    @(negedge clk); rst_jtag = 1'b0; reg_wr = 1'b0;
    chk("R8 jtag reset wins over write", obs(), 8'hA0);

    // R6 lock
    wr(1'b0, 8'h7C);
    wr(1'b1, 8'h00);
    chk("R6 zero write does not lock", obs(), 8'hBF);
    wr(1'b1, 8'h01);
    chk("R6 lock closes all", obs(), 8'h80);
    rd(1'b1, r); chk("R6 lock readback", r, 8'h01);
    @(negedge clk); rst_wdt = 1'b1; @(negedge clk); rst_wdt = 1'b0;
    rd(1'b1, r); chk("R6 lock survives soft reset", r, 8'h01);
    wr(1'b1, 8'h00);
    rd(1'b1, r); chk("R6 lock survives zero write", r, 8'h01);

    // R7 writes ignored while locked
    wr(1'b0, 8'h01);
    chk("R7 concat unchanged while locked", {7'h0, chain_concat}, 8'h00);
    rd(1'b0, r); chk("R7 readback unchanged while locked", r, 8'h02);

    // R6 power-on reset clears lock
    por();
    rd(1'b1, r); chk("R6 por clears lock", r, 8'h00);
    wr(1'b0, 8'h04);
    chk("R6 writes accepted after por", obs(), 8'hB0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule